// File: doc/BRIEF.md
# Byte-Level I2C Master Engine

This block is a single-master I2C controller that performs one bus action per host command. The host writes a command word that carries an enable bit, a launch bit, START and STOP requests and an acknowledge-enable bit. The engine then carries out one action: a START or a repeated START, the transfer of one byte in either direction with its acknowledge slot, or a STOP. When the action is over it raises a done flag and posts an 8-bit status code that names the outcome.

The direction of each byte is worked out by the engine. The first byte after any START is an address byte and is always transmitted. Its least significant bit selects read (1) or write (0) mode for the data bytes that follow. The SCL rate comes from an 8-bit divider and a 2-bit prescaler. Both pads are open-drain: each output pulls its line low when it is 1, and the engine reads the real SDA level back to obtain acknowledges and received data. Arbitration between masters, slave clock stretching and slave operation are not part of the design.

Top module: `i2c_byte_master`

## Requirements
- R1: While a byte is on the bus, every SCL high phase and every SCL low phase lasts 8 + rate_div * 4^rate_pre clock cycles, which gives a full SCL period of 16 + 2 * rate_div * 4^rate_pre cycles. SCL changes level only at the boundary of a phase.
- R2: An action is launched only by a cycle with cmd_wr, cmd_go and cmd_en all high while the engine is idle. A command with cmd_en or cmd_go low, and any command written while an action is running, is ignored. done drops on the launch edge and rises on the edge after the last bus phase. An action of N phases therefore raises done N * (8 + rate_div * 4^rate_pre) + 1 edges after the launch edge. status changes only on the edge where done rises.
- R3: With cmd_sta set and the bus free, the engine makes a START in 3 phases: SDA falls while SCL is high. It then holds SCL and SDA low, owns the bus, and posts status 0x08.
- R4: With cmd_sta set and the bus already owned, the engine makes a repeated START in 4 phases: SDA is released while SCL is low, then SDA falls while SCL is high. It posts status 0x10.
- R5: The first byte after a START or repeated START is the address. It is taken from the data register and sent MSB first in 18 phases. Bit 0 of this byte is the read/write bit. The status is 0x18 (write, ACK), 0x20 (write, NACK), 0x40 (read, ACK) or 0x48 (read, NACK). ACK means SDA is low in the ninth bit.
- R6: After a write address, a command with neither cmd_sta nor cmd_sto sends the data register and posts 0x28 when the slave answers ACK or 0x30 when it answers NACK.
- R7: After a read address, a command with neither cmd_sta nor cmd_sto receives one byte, MSB first. With cmd_ack set, the engine pulls SDA low in the ninth bit and posts 0x50. With cmd_ack clear, it leaves SDA released and posts 0x58. The byte appears unsigned on data_out once done is high.
- R8: With cmd_sto set, cmd_sta clear and the bus owned, the engine makes a STOP in 3 phases: SDA rises while SCL is high. It then leaves both pads released, frees the bus and posts status 0xF8.
- R9: During a byte transfer, SDA changes only while SCL is low. SDA edges while SCL is high happen only as START and STOP.
- R10: After reset, done is 0, status is 0xF8, data_out is 0x00 and both pads are released.
- R11: A byte command or a STOP command issued while the bus is free makes no bus activity. It completes one edge after launch with status 0xF8.
- R12: When cmd_sta and cmd_sto are both set, the START (or repeated START) is made and the STOP request is dropped.
- R13: A data_wr pulse while an action is running does not change the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_go | input | 1 | Launch bit: clears done and starts the action |
| cmd_en | input | 1 | Engine enable bit |
| cmd_sta | input | 1 | Request a START or repeated START |
| cmd_sto | input | 1 | Request a STOP |
| cmd_ack | input | 1 | Drive ACK after a received byte |
| data_wr | input | 1 | Data register write strobe |
| data_in | input | 8 | Byte written to the data register |
| rate_div | input | BR_W | Bit-rate divider |
| rate_pre | input | 2 | Prescaler select, factor 4^rate_pre |
| done | output | 1 | Action complete flag |
| status | output | 8 | Outcome code of the last action |
| data_out | output | 8 | Data register contents |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The bench builds the engine with the default BR_W of 8 and changes rate_div and rate_pre at run time. It uses (2,0), (1,1) and (0,0), which give phase lengths of 10, 12 and 8 cycles. These settings reach the prescaler path, the shortest legal phase and a rate change between a repeated START and the address that follows it. An open-drain slave model on the wires can answer ACK or NACK and can return bytes. With it, every status code is produced, and so are a NACKed final read byte and a STOP that follows it.

// File: rtl/i2c_pkg.sv
package i2c_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RS0, S_STA, S_STB, S_STC, S_LO, S_HI, S_SPA, S_SPB, S_SPC
  } seq_state_t;

  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RSTART  = 8'h10;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_AW_NACK = 8'h20;
  localparam logic [7:0] ST_DT_ACK  = 8'h28;
  localparam logic [7:0] ST_DT_NACK = 8'h30;
  localparam logic [7:0] ST_AR_ACK  = 8'h40;
  localparam logic [7:0] ST_AR_NACK = 8'h48;
  localparam logic [7:0] ST_DR_ACK  = 8'h50;
  localparam logic [7:0] ST_DR_NACK = 8'h58;
  localparam logic [7:0] ST_IDLE    = 8'hF8;
endpackage

// File: rtl/i2c_rate_gen.sv
module i2c_rate_gen #(
  parameter int BR_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [BR_W-1:0] rate_div,
  input  logic [1:0]      rate_pre,
  output logic            step_end,
  output logic            early
);
  localparam int HW = BR_W + 7;

  logic [HW-1:0] half;
  logic [HW-1:0] cnt;

  // phase length: fixed 8 plus divider scaled by 4^prescale
  assign half     = HW'(8) + (HW'(rate_div) << {rate_pre, 1'b0});
  assign step_end = run && (cnt >= half - HW'(1));
  assign early    = run && (cnt == HW'(1));

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (step_end) cnt <= '0;
    else               cnt <= cnt + HW'(1);
  end
endmodule

// File: rtl/i2c_seq.sv
module i2c_seq
  import i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       launch,
  input  logic       c_sta,
  input  logic       c_sto,
  input  logic       c_ack,
  input  logic [7:0] tx_byte,
  input  logic       step_end,
  input  logic       early,
  input  logic       sda_in,
  output logic       run,
  output logic       busy,
  output logic       fin,
  output logic       fin_rx,
  output logic [7:0] fin_status,
  output logic [7:0] rx_byte,
  output logic       scl_pull,
  output logic       sda_pull
);
  seq_state_t state;
  logic       owned, addr_next, rd_mode, cur_addr, cur_tx, cur_rs, ack_en;
  logic [7:0] sh;
  logic [3:0] bitn;
  logic       sda_lvl;
  logic [7:0] byte_code;

  assign run     = (state != S_IDLE);
  assign busy    = run || fin;
  assign rx_byte = sh;

  // SDA level wanted during the current phase
  always_comb begin
    unique case (state)
      S_STB, S_STC, S_SPA, S_SPB: sda_lvl = 1'b1;
      S_LO: begin
        if (bitn == 4'd8) sda_lvl = cur_tx ? 1'b0 : ack_en;
        else              sda_lvl = cur_tx ? ~sh[7] : 1'b0;
      end
      S_HI:    sda_lvl = sda_pull;
      default: sda_lvl = 1'b0;
    endcase
  end

  // outcome code of a finished byte, acknowledge read from the line
  always_comb begin
    if (cur_addr)
      byte_code = rd_mode ? (!sda_in ? ST_AR_ACK : ST_AR_NACK)
                          : (!sda_in ? ST_AW_ACK : ST_AW_NACK);
    else if (cur_tx)
      byte_code = !sda_in ? ST_DT_ACK : ST_DT_NACK;
    else
      byte_code = ack_en ? ST_DR_ACK : ST_DR_NACK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; owned <= 1'b0; addr_next <= 1'b0; rd_mode <= 1'b0;
      cur_addr <= 1'b0; cur_tx <= 1'b0; cur_rs <= 1'b0; ack_en <= 1'b0;
      sh <= '0; bitn <= '0; fin <= 1'b0; fin_rx <= 1'b0;
      fin_status <= ST_IDLE; scl_pull <= 1'b0; sda_pull <= 1'b0;
    end else begin
      fin    <= 1'b0;
      fin_rx <= 1'b0;
      if (state == S_IDLE) begin
        if (launch) begin
          ack_en <= c_ack;
          cur_rs <= owned;
          if (c_sta) begin
            state <= owned ? S_RS0 : S_STA;
          end else if (c_sto && owned) begin
            state <= S_SPA;
          end else if (!c_sto && owned) begin
            state     <= S_LO;
            bitn      <= '0;
            sh        <= tx_byte;
            cur_addr  <= addr_next;
            cur_tx    <= addr_next || !rd_mode;
            addr_next <= 1'b0;
            if (addr_next) rd_mode <= tx_byte[0];
          end else begin
            fin        <= 1'b1;
            fin_status <= ST_IDLE;
          end
        end
      end else begin
        if (early) sda_pull <= sda_lvl;
        if (step_end) begin
          unique case (state)
            S_RS0: begin state <= S_STA; scl_pull <= 1'b0; end
            S_STA: state <= S_STB;
            S_STB: begin state <= S_STC; scl_pull <= 1'b1; end
            S_STC: begin
              state <= S_IDLE; owned <= 1'b1; addr_next <= 1'b1; rd_mode <= 1'b0;
              fin <= 1'b1; fin_status <= cur_rs ? ST_RSTART : ST_START;
            end
            S_LO: begin state <= S_HI; scl_pull <= 1'b0; end
            S_HI: begin
              scl_pull <= 1'b1;
              if (bitn != 4'd8) begin
                sh    <= {sh[6:0], sda_in};
                bitn  <= bitn + 4'd1;
                state <= S_LO;
              end else begin
                state      <= S_IDLE;
                fin        <= 1'b1;
                fin_rx     <= !cur_tx;
                fin_status <= byte_code;
              end
            end
            S_SPA: begin state <= S_SPB; scl_pull <= 1'b0; end
            S_SPB: state <= S_SPC;
            S_SPC: begin
              state <= S_IDLE; owned <= 1'b0; addr_next <= 1'b0; rd_mode <= 1'b0;
              fin <= 1'b1; fin_status <= ST_IDLE;
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end

  // SDA must not move through an SCL high phase of a byte
  assert_sda_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (state == S_HI && $past(state) == S_HI) |-> $stable(sda_pull))
    else $error("SDA moved while SCL high");

  // SCL edges only at phase boundaries from the rate generator
  assert_scl_on_phase_R1: assert property (@(posedge clk) disable iff (rst)
    !$stable(scl_pull) |-> $past(step_end))
    else $error("SCL changed inside a phase");

  // SDA may only change while SCL is pulled or a START/STOP phase runs
  assert_sda_low_scl_R9: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_pull) && !$past(scl_pull)) |->
      ($past(state) == S_STB || $past(state) == S_SPC ||
       $past(state) == S_STA || $past(state) == S_RS0))
    else $error("SDA edge with SCL released outside START/STOP");
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_pkg::*;
#(
  parameter int BR_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_wr,
  input  logic            cmd_go,
  input  logic            cmd_en,
  input  logic            cmd_sta,
  input  logic            cmd_sto,
  input  logic            cmd_ack,
  input  logic            data_wr,
  input  logic [7:0]      data_in,
  input  logic [BR_W-1:0] rate_div,
  input  logic [1:0]      rate_pre,
  output logic            done,
  output logic [7:0]      status,
  output logic [7:0]      data_out,
  output logic            scl_pull,
  output logic            sda_pull,
  input  logic            sda_in
);
  logic       run, busy, fin, fin_rx, step_end, early, launch;
  logic [7:0] fin_status, rx_byte, data_reg;

  assign launch   = cmd_wr && cmd_go && cmd_en && !busy;
  assign data_out = data_reg;

  i2c_rate_gen #(.BR_W(BR_W)) u_rate (
    .clk(clk), .rst(rst), .run(run), .rate_div(rate_div), .rate_pre(rate_pre),
    .step_end(step_end), .early(early)
  );

  i2c_seq u_seq (
    .clk(clk), .rst(rst), .launch(launch), .c_sta(cmd_sta), .c_sto(cmd_sto),
    .c_ack(cmd_ack), .tx_byte(data_reg), .step_end(step_end), .early(early),
    .sda_in(sda_in), .run(run), .busy(busy), .fin(fin), .fin_rx(fin_rx),
    .fin_status(fin_status), .rx_byte(rx_byte), .scl_pull(scl_pull),
    .sda_pull(sda_pull)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      status   <= ST_IDLE;
      data_reg <= '0;
    end else begin
      if (launch)   done <= 1'b0;
      else if (fin) done <= 1'b1;
      if (fin) status <= fin_status;
      if (data_wr && !busy) data_reg <= data_in;
      if (fin_rx)           data_reg <= rx_byte;
    end
  end

  assert_done_low_busy_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done)
    else $error("done high during an action");

  assert_status_with_done_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(status) |-> $rose(done))
    else $error("status changed without done rising");

  assert_data_hold_R13: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && !$past(fin_rx)) |-> $stable(data_reg))
    else $error("data register changed during an action");
endmodule

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;
  logic clk = 1'b0, rst = 1'b1;
  logic cmd_wr = 0, cmd_go = 0, cmd_en = 0, cmd_sta = 0, cmd_sto = 0, cmd_ack = 0;
  logic data_wr = 0;
  logic [7:0] data_in = 8'h00;
  logic [7:0] rate_div = 8'd2;
  logic [1:0] rate_pre = 2'd0;
  logic done, scl_pull, sda_pull, sda_in;
  logic [7:0] status, data_out;
  logic slv_pull = 1'b0;

  int vecs = 0, errs = 0, exp_h = 10, cyc = 0;
  bit in_byte = 0, have_rise = 0, finished = 0;
  int last_rise = 0, starts = 0, stops = 0, nbit = 0, txi = 0;
  bit prev_scl = 1, prev_sda = 1, is_addr = 0, rd = 0, txing = 0, mack = 0, ack_cfg = 1;
  logic [7:0] sh = 0, rx_last = 0;
  logic [7:0] slv_bytes [2];

  always #4 clk = ~clk;

  assign sda_in = ~(sda_pull | slv_pull);

  i2c_byte_master #(.BR_W(8)) dut (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_go(cmd_go), .cmd_en(cmd_en),
    .cmd_sta(cmd_sta), .cmd_sto(cmd_sto), .cmd_ack(cmd_ack), .data_wr(data_wr),
    .data_in(data_in), .rate_div(rate_div), .rate_pre(rate_pre), .done(done),
    .status(status), .data_out(data_out), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .sda_in(sda_in)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // slave model and bus monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      prev_scl = 1; prev_sda = 1; slv_pull = 0; nbit = 0; txing = 0; is_addr = 0;
    end else begin
      bit sl, sd;
      sl = ~scl_pull;
      sd = ~(sda_pull | slv_pull);
      if (sl && prev_scl && prev_sda && !sd) begin
        starts++; nbit = 0; is_addr = 1; txing = 0; slv_pull = 0;
        chk(!in_byte, "R9 START seen inside byte", 1, 0);
      end else if (sl && prev_scl && !prev_sda && sd) begin
        stops++; nbit = 0; txing = 0;
        chk(!in_byte, "R9 STOP seen inside byte", 1, 0);
      end else if (!prev_scl && sl) begin
        if (in_byte && have_rise)
          chk(cyc - last_rise == 2 * exp_h, "R1 SCL period", cyc - last_rise, 2 * exp_h);
        last_rise = cyc; have_rise = 1;
        if (nbit < 8) begin sh = {sh[6:0], sd}; nbit++; end
        else if (nbit == 8) begin if (txing) mack = !sd; nbit = 9; end
      end else if (prev_scl && !sl) begin
        if (in_byte && have_rise)
          chk(cyc - last_rise == exp_h, "R1 SCL high time", cyc - last_rise, exp_h);
        if (nbit == 8) begin
          if (!txing) begin
            rx_last = sh;
            if (is_addr) rd = sh[0];
            slv_pull = ack_cfg;
          end else slv_pull = 0;
        end else if (nbit == 9) begin
          nbit = 0;
          if (is_addr) begin is_addr = 0; txing = rd && ack_cfg; txi = 0; end
          else if (txing) begin txing = mack; txi++; end
          slv_pull = (txing && txi < 2) ? !slv_bytes[txi][7] : 1'b0;
        end else if (txing && txi < 2) begin
          slv_pull = !slv_bytes[txi][7 - nbit];
        end
      end
      prev_scl = sl;
      prev_sda = ~(sda_pull | slv_pull);
    end
  end

  task automatic set_rate(input int b, input int p);
    @(negedge clk);
    rate_div = 8'(b); rate_pre = 2'(p);
    exp_h = 8 + b * (4 ** p);
  endtask

  task automatic write_data(input logic [7:0] v);
    @(negedge clk); data_wr = 1; data_in = v;
    @(negedge clk); data_wr = 0;
  endtask

  task automatic run_op(input bit sta, input bit sto, input bit ack, input int steps,
                        input logic [7:0] exp_st, input string tag, input bit bop,
                        input int poke);
    int total;
    @(negedge clk);
    cmd_sta = sta; cmd_sto = sto; cmd_ack = ack; cmd_en = 1; cmd_go = 1; cmd_wr = 1;
    in_byte = bop; have_rise = 0;
    @(negedge clk); cmd_wr = 0;
    total = steps * exp_h + 1;
    for (int j = 0; j <= total; j++) begin
      if (j > 0) @(negedge clk);
      if (poke > 0 && j == poke) begin
        cmd_wr = 1; cmd_sta = 1; data_wr = 1; data_in = 8'hFF;
      end else if (poke > 0 && j == poke + 1) begin
        cmd_wr = 0; cmd_sta = sta; data_wr = 0;
      end
      chk(done == (j == total), {tag, " R2 done timing"}, int'(done), int'(j == total));
    end
    chk(status == exp_st, {tag, " status"}, status, exp_st);
    in_byte = 0;
  endtask

  task automatic ignored_cmd(input bit en, input bit go, input bit exp_done);
    logic [7:0] st0;
    st0 = status;
    @(negedge clk);
    cmd_en = en; cmd_go = go; cmd_sta = 1; cmd_wr = 1;
    @(negedge clk); cmd_wr = 0;
    for (int j = 0; j < 30; j++) begin
      @(negedge clk);
      chk(!scl_pull && !sda_pull, "R2 ignored command left pads idle", {scl_pull, sda_pull}, 0);
    end
    chk(done == exp_done, "R2 ignored command kept done", done, exp_done);
    chk(status == st0, "R2 ignored command kept status", status, st0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired (R2 completion)");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    slv_bytes[0] = 8'hC3; slv_bytes[1] = 8'h96;
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 0;
    // R10 reset state
    chk(done == 0, "R10 done after reset", done, 0);
    chk(status == 8'hF8, "R10 status after reset", status, 8'hF8);
    chk(data_out == 8'h00, "R10 data after reset", data_out, 0);
    chk(!scl_pull && !sda_pull, "R10 pads after reset", {scl_pull, sda_pull}, 0);

    set_rate(2, 0);
    ignored_cmd(0, 1, 0);                 // R2 enable low
    ignored_cmd(1, 0, 0);                 // R2 launch bit low

    // R11 byte and stop with bus free
    run_op(0, 0, 0, 0, 8'hF8, "R11 byte when free", 0, 0);
    chk(!scl_pull && !sda_pull && starts == 0, "R11 no bus activity", starts, 0);
    run_op(0, 1, 0, 0, 8'hF8, "R11 stop when free", 0, 0);
    chk(stops == 0, "R11 no stop generated", stops, 0);

    // R3 START
    run_op(1, 0, 0, 3, 8'h08, "R3 start", 0, 0);
    chk(starts == 1, "R3 START on bus", starts, 1);
    chk(scl_pull && sda_pull, "R3 bus held low", {scl_pull, sda_pull}, 3);

    // R5 write address ACK
    ack_cfg = 1;
    write_data(8'hA4);
    run_op(0, 0, 0, 18, 8'h18, "R5 write addr ack", 1, 0);
    chk(rx_last == 8'hA4, "R5 address byte on bus", rx_last, 8'hA4);

    // R6 data ACK, with R2/R13 pokes during the transfer
    write_data(8'h5B);
    run_op(0, 0, 0, 18, 8'h28, "R6 data ack", 1, 30);
    chk(rx_last == 8'h5B, "R6 data byte on bus", rx_last, 8'h5B);
    chk(data_out == 8'h5B, "R13 data register kept", data_out, 8'h5B);
    chk(starts == 1, "R2 busy command ignored", starts, 1);

    // R6 data NACK
    ack_cfg = 0;
    write_data(8'h3C);
    run_op(0, 0, 0, 18, 8'h30, "R6 data nack", 1, 0);
    ack_cfg = 1;

    // R4 repeated START
    run_op(1, 0, 0, 4, 8'h10, "R4 repeated start", 0, 0);
    chk(starts == 2, "R4 repeated START on bus", starts, 2);

    // R5 read address, R7 receive
    set_rate(1, 1);
    write_data(8'hA5);
    run_op(0, 0, 0, 18, 8'h40, "R5 read addr ack", 1, 0);
    run_op(0, 0, 1, 18, 8'h50, "R7 receive ack", 1, 0);
    chk(data_out == 8'hC3, "R7 first received byte", data_out, 8'hC3);
    chk(mack == 1, "R7 master ACK seen", mack, 1);
    run_op(0, 0, 0, 18, 8'h58, "R7 receive nack", 1, 0);
    chk(data_out == 8'h96, "R7 second received byte", data_out, 8'h96);
    chk(mack == 0, "R7 master NACK seen", mack, 0);

    // R8 STOP
    run_op(0, 1, 0, 3, 8'hF8, "R8 stop", 0, 0);
    chk(stops == 1, "R8 STOP on bus", stops, 1);
    chk(!scl_pull && !sda_pull, "R8 pads released", {scl_pull, sda_pull}, 0);

    // R12 start wins over stop
    set_rate(0, 0);
    run_op(1, 1, 0, 3, 8'h08, "R12 start and stop", 0, 0);
    chk(stops == 1 && starts == 3, "R12 no STOP made", stops, 1);

    // R5 write address NACK, read address NACK
    ack_cfg = 0;
    write_data(8'h50);
    run_op(0, 0, 0, 18, 8'h20, "R5 write addr nack", 1, 0);
    run_op(1, 0, 0, 4, 8'h10, "R4 repeated start fast", 0, 0);
    write_data(8'h51);
    run_op(0, 0, 0, 18, 8'h48, "R5 read addr nack", 1, 0);
    ack_cfg = 1;
    run_op(0, 1, 0, 3, 8'hF8, "R8 stop fast", 0, 0);
    chk(stops == 2, "R8 second STOP", stops, 2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule